// File: doc/BRIEF.md
# Pin edge cause unit

This block watches a bank of general-purpose input pins, finds edges on them and turns those edges into interrupt requests. Each pad input first passes through a synchronizer chain. The synchronized value is then compared with its value from the cycle before. When a pin sees a rising edge with its rise enable set, or a falling edge with its fall enable set, the block sets a sticky cause bit for that pin.

The cause bits are gated by a per-pin event enable. The result is the pending word. One shared, active-high interrupt line is high whenever any bit of the pending word is set. Software reads the pending word, handles each set bit and then writes ones to the clear register to drop those causes. All registers sit on a small memory-mapped bus with a one-cycle read response.

The bus side is a two-state machine.
- **ST_IDLE:** no read data is being returned.
- **ST_RESP:** the registered read data is presented with `bus_rvalid` high.

The transitions are:
- **IDLE->RESP:** taken on a read request.
- **RESP->RESP:** taken on a back-to-back read.
- **RESP->IDLE:** taken when there is no read request.

Writes take effect in the cycle they are presented, in either state.

Top module: `pin_edge_cause_unit`

## Requirements
- R1: After reset, the rise, fall and event enable registers read 0, every cause bit is 0, `irq` is low and `bus_rvalid` is low.
- R2: A rising edge on pin i sets cause bit i when bit i of the rise enable register (offset 0x44) is 1.
- R3: A falling edge on pin i sets cause bit i when bit i of the fall enable register (offset 0x48) is 1.
- R4: With both its rise and fall enables set, a pin sets its cause bit on either edge direction.
- R5: An edge whose direction is not enabled for that pin leaves the cause bit at 0.
- R6: Reading offset 0x80 returns the cause bits ANDed with the event enable register (offset 0x94). A cause latched while its event enable was 0 stays set and shows up once the enable is set.
- R7: Writing to offset 0x98 clears every cause bit whose write-data bit is 1. Bits written as 0 keep their value.
- R8: When a new enabled edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly when at least one bit of (cause AND event enable) is 1.
- R10: A read request (`bus_sel`=1, `bus_wr`=0) returns data with `bus_rvalid`=1 in the next cycle.
  - Offset 0x98 and unmapped offsets read 0.
  - A write to offset 0x80 changes nothing.
- R11: With the default two synchronizer stages, a pad change made before clock edge 1 sets its cause at clock edge 3, so `irq` goes high after that edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pad_in | input | NPINS | Asynchronous pad inputs |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after the request |
| irq | output | 1 | Shared level-high interrupt |

## Verification
The assertions take for granted that each synchronized pin changes at most once per clock cycle. They also assume that a new cause can only come from the last two synchronized samples together with the enables of the previous cycle, so pads are never driven during reset. The bench keeps to this by changing pads and bus signals only at falling clock edges. It also holds every pad level for several cycles before reading the pending word, except in the deliberate same-cycle clear-versus-edge case.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
    localparam int          BUS_AW      = 8;
    localparam logic [7:0]  OFS_RISE_EN = 8'h44;
    localparam logic [7:0]  OFS_FALL_EN = 8'h48;
    localparam logic [7:0]  OFS_PENDING = 8'h80;
    localparam logic [7:0]  OFS_EVT_EN  = 8'h94;
    localparam logic [7:0]  OFS_CLEAR   = 8'h98;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                chain[k] <= chain[k-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cause_bank.sv
module cause_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] cause
);
    logic [W-1:0] prev_q;
    logic [W-1:0] cause_q;
    logic [W-1:0] hit;

    // Per-pin edge qualification; a fresh hit overrides a clear.
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign hit[i] = (pins[i] & ~prev_q[i] & rise_en[i])
                      | (~pins[i] & prev_q[i] & fall_en[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            cause_q <= '0;
        end else begin
            prev_q  <= pins;
            cause_q <= (cause_q & ~clr_vec) | hit;
        end
    end

    assign cause = cause_q;
endmodule

// File: rtl/cause_regs.sv
module cause_regs
    import edge_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [BUS_AW-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      cause,
    output logic [W-1:0]      rise_en,
    output logic [W-1:0]      fall_en,
    output logic [W-1:0]      evt_en,
    output logic [W-1:0]      clr_vec,
    output logic [W-1:0]      rdata,
    output logic              rvalid
);
    bus_state_e   state_q, state_d;
    logic         rd_req;
    logic         wr_req;
    logic [W-1:0] rd_mux;
    logic [W-1:0] rdata_q;

    assign rd_req = sel & ~wr;
    assign wr_req = sel & wr;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rvalid = (state_q == ST_RESP);
        rdata  = rvalid ? rdata_q : '0;
    end

    always_comb begin
        unique case (addr)
            OFS_RISE_EN: rd_mux = rise_en;
            OFS_FALL_EN: rd_mux = fall_en;
            OFS_PENDING: rd_mux = cause & evt_en;
            OFS_EVT_EN:  rd_mux = evt_en;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            rise_en <= '0;
            fall_en <= '0;
            evt_en  <= '0;
        end else begin
            if (rd_req) rdata_q <= rd_mux;
            if (wr_req && addr == OFS_RISE_EN) rise_en <= wdata;
            if (wr_req && addr == OFS_FALL_EN) fall_en <= wdata;
            if (wr_req && addr == OFS_EVT_EN)  evt_en  <= wdata;
        end
    end

    assign clr_vec = (wr_req && addr == OFS_CLEAR) ? wdata : '0;
endmodule

// File: rtl/pin_edge_cause_unit.sv
module pin_edge_cause_unit
    import edge_irq_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pad_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              bus_rvalid,
    output logic              irq
);
    logic [NPINS-1:0] sync_pins;
    logic [NPINS-1:0] rise_en;
    logic [NPINS-1:0] fall_en;
    logic [NPINS-1:0] evt_en;
    logic [NPINS-1:0] clr_vec;
    logic [NPINS-1:0] cause_q;

    pin_sync #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_pins)
    );

    cause_bank #(
        .W (NPINS)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .pins    (sync_pins),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .clr_vec (clr_vec),
        .cause   (cause_q)
    );

    cause_regs #(
        .W (NPINS)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .cause   (cause_q),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .evt_en  (evt_en),
        .clr_vec (clr_vec),
        .rdata   (bus_rdata),
        .rvalid  (bus_rvalid)
    );

    assign irq = |(cause_q & evt_en);
endmodule

// File: rtl/pin_edge_cause_checker.sv
module pin_edge_cause_checker
    import edge_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [NPINS-1:0]  sync_pins,
    input logic [NPINS-1:0]  cause_q,
    input logic [NPINS-1:0]  clr_vec,
    input logic [NPINS-1:0]  rise_en,
    input logic [NPINS-1:0]  fall_en,
    input logic [NPINS-1:0]  evt_en,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_rdata,
    input logic              bus_rvalid,
    input logic              irq
);
    logic pend_rd_q;

    always_ff @(posedge clk) begin
        if (rst) pend_rd_q <= 1'b0;
        else     pend_rd_q <= bus_sel && !bus_wr && (bus_addr == OFS_PENDING);
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !bus_rvalid && cause_q == '0)); // R1

    AST_CAUSE_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
        ((cause_q & ~$past(cause_q)) &
         ~(( $past(sync_pins) & ~$past(sync_pins, 2) & $past(rise_en)) |
           (~$past(sync_pins) &  $past(sync_pins, 2) & $past(fall_en)))) == '0); // R5

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(cause_q) & ~$past(clr_vec) & ~cause_q) == '0); // R7

    AST_PENDING_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && pend_rd_q) |-> (bus_rdata == ($past(cause_q) & $past(evt_en)))); // R6

    AST_READ_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(bus_sel && !bus_wr)); // R10

    AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
        (evt_en == '0) |-> !irq); // R9
endmodule

bind pin_edge_cause_unit pin_edge_cause_checker #(
    .NPINS (NPINS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sync_pins  (sync_pins),
    .cause_q    (cause_q),
    .clr_vec    (clr_vec),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .evt_en     (evt_en),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq        (irq)
);

// File: tb/tb_pin_edge_cause_unit.sv
`timescale 1ns/1ps
module tb_pin_edge_cause_unit;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pad_in = '0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         bus_rvalid;
    logic         irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pin_edge_cause_unit #(.NPINS(N), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .pad_in(pad_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        chk("R10 rvalid", {31'b0, bus_rvalid}, 32'd1);
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'b0, irq}, '0);
        chk("R1 rvalid", {31'b0, bus_rvalid}, '0);
        rd(8'h44, v); chk("R1 rise_en", v, '0);
        rd(8'h48, v); chk("R1 fall_en", v, '0);
        rd(8'h94, v); chk("R1 evt_en", v, '0);
        rd(8'h80, v); chk("R1 pending", v, '0);

        // Sweep: every pin, every enable combination, rise then fall
        wr(8'h94, '1);
        for (int i = 0; i < N; i++) begin
            for (int c = 0; c < 4; c++) begin
                logic [N-1:0] b;
                logic [N-1:0] e1;
                logic [N-1:0] e2;
                string tg;
                b  = 32'd1 << i;
                e1 = c[0] ? b : '0;
                e2 = (c != 0) ? b : '0;
                tg = (c == 0) ? "R5" : (c == 1) ? "R2" : (c == 2) ? "R3" : "R4";
                wr(8'h44, c[0] ? b : '0);
                wr(8'h48, c[1] ? b : '0);
                pad_in = pad_in | b;
                idle(4);
                rd(8'h80, v); chk({tg, " after rise"}, v, e1);
                chk("R9 irq after rise", {31'b0, irq}, {31'b0, |e1});
                pad_in = pad_in & ~b;
                idle(4);
                rd(8'h80, v); chk({tg, " after fall"}, v, e2);
                chk("R9 irq after fall", {31'b0, irq}, {31'b0, |e2});
                wr(8'h98, '1);
                rd(8'h80, v); chk("R7 clear all", v, '0);
            end
        end

        // R6: cause latched while event enable off
        wr(8'h94, '0);
        wr(8'h48, '0);
        wr(8'h44, '1);
        pad_in[5] = 1'b1;
        idle(4);
        rd(8'h80, v); chk("R6 masked pending", v, '0);
        chk("R9 masked irq", {31'b0, irq}, '0);
        wr(8'h94, 32'h20);
        rd(8'h80, v); chk("R6 unmasked pending", v, 32'h20);
        chk("R9 unmasked irq", {31'b0, irq}, 32'd1);
        pad_in[5] = 1'b0;
        wr(8'h94, '1);
        wr(8'h98, '1);

        // R7 partial clear
        pad_in[7:0] = 8'hFF;
        idle(4);
        rd(8'h80, v); chk("R2 multi rise", v, 32'hFF);
        wr(8'h98, 32'h0F);
        rd(8'h80, v); chk("R7 partial clear", v, 32'hF0);

        // R10: write to pending is ignored, write-only and unmapped read 0
        wr(8'h80, 32'h0000_FF0F);
        rd(8'h80, v); chk("R10 pending write ignored", v, 32'hF0);
        rd(8'h98, v); chk("R10 clear reads zero", v, '0);
        rd(8'h10, v); chk("R10 unmapped reads zero", v, '0);
        rd(8'h44, v); chk("R10 rise_en readback", v, '1);
        wr(8'h98, '1);
        pad_in[7:0] = 8'h00;
        idle(4);
        wr(8'h98, '1);

        // R8: clear and new edge on the same bit in the same cycle
        wr(8'h44, 32'h100);
        wr(8'h48, '0);
        pad_in[8] = 1'b1;
        idle(2);
        wr(8'h98, 32'h100);
        rd(8'h80, v); chk("R8 edge beats clear", v, 32'h100);
        wr(8'h98, 32'h100);
        rd(8'h80, v); chk("R7 later clear", v, '0);

        // R11 latency through the synchronizer
        pad_in[8] = 1'b0;
        idle(4);
        pad_in[8] = 1'b1;
        @(negedge clk); chk("R11 irq after edge 1", {31'b0, irq}, '0);
        @(negedge clk); chk("R11 irq after edge 2", {31'b0, irq}, '0);
        @(negedge clk); chk("R11 irq after edge 3", {31'b0, irq}, 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule